// File: doc/BRIEF.md
# Dual channel output control logic

This block is the digital control core of a two-channel low-side switch driver. Each channel has a parallel input pin and a matching command bit held in a register. A two-bit mode field per channel chooses how the pin and the command bit combine into that channel's gate-enable output. The choices are the pin alone, the bit alone, their OR, or their AND. A per-channel slew-select bit is driven out to the analog stage. The same bit also picks which overload switch-off delay code applies while the second current limit is active.

Configuration arrives as single-cycle address/data write strobes, which model the serial interface after deframing. A write to the power register puts the block to sleep. In sleep both gates are forced off, the bias/diagnosis enable drops and the channel command register is cleared. Mode and slew settings are kept. Only an explicit wake write leaves sleep. After that write the gates stay off for a programmable wake-up delay, counted in clock cycles. At the default parameters this delay is 100 µs at 200 MHz.

Top module: `dual_out_ctrl`

## Requirements
- R1: After reset: `gate_o` = 0, `slew_o` = 0, `ovld_code_o` = 0, `bias_en_o` = 1, the command register is 0 and every channel is in pin-only mode.
- R2: Pin k drives only gate k. There is no cross-mapping between channels.
- R3: Register address 1 holds the mode, bits [2k+1:2k] for channel k. The codes are 00 pin only, 01 command bit only, 10 pin OR bit, 11 pin AND bit. Register address 0 holds the command bit for channel k in bit k.
- R4: A pin change reaches `gate_o` at the third rising edge after it. A register write at edge E reaches `gate_o` at edge E+1.
- R5: Register address 2 holds the slew select for channel k in bit k. `slew_o` follows that bit one edge after the write, and the value is kept across sleep.
- R6: `ovld_code_o[k*CODE_W +: CODE_W]` is SR2_CODE when `lim2_i[k]` is high and slew bit k is 1. It is SR1_CODE when `lim2_i[k]` is high and slew bit k is 0. It is 0 when `lim2_i[k]` is low or the block is asleep. The output is registered one edge after its inputs.
- R7: A write to address 3 with data bit 0 set puts the block to sleep. From the edge after that write, `gate_o` = 0 and `bias_en_o` = 0.
- R8: Entering sleep clears the command register. The mode and slew registers keep their values.
- R9: While asleep, pin activity, writes to addresses 0 to 2, and address 3 writes without data bit 1 all leave the block asleep.
- R10: A write to address 3 at edge E0 with data bit 1 set and bit 0 clear wakes a sleeping block. `bias_en_o` returns at E0+1. `gate_o` stays 0 through edge E0+WAKE_CYCLES and follows the combine result from E0+WAKE_CYCLES+1. Bit 0 takes priority when both bits are set. A wake write while awake has no effect.
- R11: Writes during sleep are stored. A command written during sleep acts on the gates only once the wake delay has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NCH | Parallel channel inputs, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 2*NCH | Register write data |
| lim2_i | input | NCH | Second current limit active, per channel |
| gate_o | output | NCH | Gate enable per channel |
| slew_o | output | NCH | Slew select per channel |
| ovld_code_o | output | NCH*CODE_W | Overload switch-off delay code per channel |
| bias_en_o | output | 1 | Bias and diagnosis enable |

## Verification
The combine function is swept over all sixteen mode pairs times all sixteen pin/bit patterns. Both channels run at once with independent values, so a wrong mode decode, a swapped channel or a mixed-up pin and bit all show up as a mismatch on one gate. The slew and limit inputs are swept across all four-by-four patterns to tell apart the two delay codes from the quiet zero. The sleep sequences place a non-zero command before sleep, a mode change and a command during sleep, and pin toggling while asleep. They sample the gates exactly on the last held edge and the first enabled edge of the wake window. This separates clearing from retention and catches an off-by-one wake counter.

// File: rtl/dual_out_pkg.sv
`timescale 1ns/1ps
package dual_out_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] A_SLEW = 2'd2;
  localparam logic [ADDR_W-1:0] A_PWR  = 2'd3;

  typedef enum logic [1:0] {
    MODE_PIN = 2'b00,
    MODE_CMD = 2'b01,
    MODE_OR  = 2'b10,
    MODE_AND = 2'b11
  } comb_mode_e;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'b00,
    PWR_SLEEP = 2'b01,
    PWR_WAKE  = 2'b10
  } pwr_state_e;

  function automatic logic combine(comb_mode_e m, logic pin, logic bit_v);
    logic r;
    case (m)
      MODE_PIN: r = pin;
      MODE_CMD: r = bit_v;
      MODE_OR:  r = pin | bit_v;
      default:  r = pin & bit_v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dual_out_sync.sv
`timescale 1ns/1ps
module dual_out_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

endmodule

// File: rtl/dual_out_regs.sv
`timescale 1ns/1ps
module dual_out_regs #(
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we_i,
  input  logic             mode_we_i,
  input  logic             slew_we_i,
  input  logic             clr_cmd_i,
  input  logic [NCH-1:0]   cmd_wdata_i,
  input  logic [2*NCH-1:0] mode_wdata_i,
  input  logic [NCH-1:0]   slew_wdata_i,
  output logic [NCH-1:0]   cmd_q,
  output logic [2*NCH-1:0] mode_q,
  output logic [NCH-1:0]   slew_q
);

  // Command register: cleared on sleep entry, otherwise written normally
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (clr_cmd_i) begin
      cmd_q <= '0;
    end else if (cmd_we_i) begin
      cmd_q <= cmd_wdata_i;
    end
  end

  // Mode and slew registers: retained across sleep
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      slew_q <= '0;
    end else begin
      if (mode_we_i) mode_q <= mode_wdata_i;
      if (slew_we_i) slew_q <= slew_wdata_i;
    end
  end

endmodule

// File: rtl/dual_out_pwr.sv
`timescale 1ns/1ps
module dual_out_pwr
  import dual_out_pkg::*;
#(
  parameter int WAKE_CYCLES = 20000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  output pwr_state_e state_o,
  output logic       run_o,
  output logic       biased_o
);

  localparam int CNT_W = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

  pwr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PWR_RUN;
      cnt_q   <= '0;
    end else if (sleep_req_i) begin
      state_q <= PWR_SLEEP;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        PWR_SLEEP: begin
          if (wake_req_i) begin
            state_q <= PWR_WAKE;
            cnt_q   <= '0;
          end
        end
        PWR_WAKE: begin
          if (cnt_q == CNT_LAST) begin
            state_q <= PWR_RUN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PWR_RUN: ;
        default: state_q <= PWR_SLEEP;
      endcase
    end
  end

  assign state_o  = state_q;
  assign run_o    = (state_q == PWR_RUN);
  assign biased_o = (state_q != PWR_SLEEP);

endmodule

// File: rtl/dual_out_chan.sv
`timescale 1ns/1ps
module dual_out_chan
  import dual_out_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int SR1_CODE = 3,
  parameter int SR2_CODE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              biased_i,
  input  logic              pin_i,
  input  logic              cmd_i,
  input  comb_mode_e        mode_i,
  input  logic              slew_sel_i,
  input  logic              lim2_i,
  output logic              gate_o,
  output logic              slew_o,
  output logic [CODE_W-1:0] code_o
);

  localparam logic [CODE_W-1:0] CODE_A = CODE_W'(SR1_CODE);
  localparam logic [CODE_W-1:0] CODE_B = CODE_W'(SR2_CODE);

  logic              gate_d;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    gate_d = run_i & combine(mode_i, pin_i, cmd_i);
    if (biased_i && lim2_i) begin
      code_d = slew_sel_i ? CODE_B : CODE_A;
    end else begin
      code_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o <= 1'b0;
      slew_o <= 1'b0;
      code_o <= '0;
    end else begin
      gate_o <= gate_d;
      slew_o <= slew_sel_i;
      code_o <= code_d;
    end
  end

endmodule

// File: rtl/dual_out_ctrl.sv
`timescale 1ns/1ps
module dual_out_ctrl
  import dual_out_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int WAKE_CYCLES = 20000,
  parameter int CODE_W      = 4,
  parameter int SR1_CODE    = 3,
  parameter int SR2_CODE    = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        pin_i,
  input  logic                  wr_en_i,
  input  logic [1:0]            wr_addr_i,
  input  logic [2*NCH-1:0]      wr_data_i,
  input  logic [NCH-1:0]        lim2_i,
  output logic [NCH-1:0]        gate_o,
  output logic [NCH-1:0]        slew_o,
  output logic [NCH*CODE_W-1:0] ovld_code_o,
  output logic                  bias_en_o
);

  logic [NCH-1:0]   pin_s;
  logic [NCH-1:0]   cmd_bits;
  logic [2*NCH-1:0] mode_bits;
  logic [NCH-1:0]   slew_bits;
  logic             wr_cmd, wr_mode, wr_slew, wr_pwr;
  logic             sleep_req, wake_req;
  pwr_state_e       pwr_state;
  logic             run, biased;

  // Write decode
  assign wr_cmd    = wr_en_i && (wr_addr_i == A_CMD);
  assign wr_mode   = wr_en_i && (wr_addr_i == A_MODE);
  assign wr_slew   = wr_en_i && (wr_addr_i == A_SLEW);
  assign wr_pwr    = wr_en_i && (wr_addr_i == A_PWR);
  assign sleep_req = wr_pwr && wr_data_i[0];
  assign wake_req  = wr_pwr && wr_data_i[1] && !wr_data_i[0];

  dual_out_sync #(.WIDTH(NCH)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_s)
  );

  dual_out_regs #(.NCH(NCH)) regs_i (
    .clk          (clk),
    .rst          (rst),
    .cmd_we_i     (wr_cmd),
    .mode_we_i    (wr_mode),
    .slew_we_i    (wr_slew),
    .clr_cmd_i    (sleep_req),
    .cmd_wdata_i  (wr_data_i[NCH-1:0]),
    .mode_wdata_i (wr_data_i),
    .slew_wdata_i (wr_data_i[NCH-1:0]),
    .cmd_q        (cmd_bits),
    .mode_q       (mode_bits),
    .slew_q       (slew_bits)
  );

  dual_out_pwr #(.WAKE_CYCLES(WAKE_CYCLES)) pwr_i (
    .clk         (clk),
    .rst         (rst),
    .sleep_req_i (sleep_req),
    .wake_req_i  (wake_req),
    .state_o     (pwr_state),
    .run_o       (run),
    .biased_o    (biased)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    dual_out_chan #(
      .CODE_W   (CODE_W),
      .SR1_CODE (SR1_CODE),
      .SR2_CODE (SR2_CODE)
    ) chan_i (
      .clk        (clk),
      .rst        (rst),
      .run_i      (run),
      .biased_i   (biased),
      .pin_i      (pin_s[k]),
      .cmd_i      (cmd_bits[k]),
      .mode_i     (comb_mode_e'(mode_bits[2*k +: 2])),
      .slew_sel_i (slew_bits[k]),
      .lim2_i     (lim2_i[k]),
      .gate_o     (gate_o[k]),
      .slew_o     (slew_o[k]),
      .code_o     (ovld_code_o[k*CODE_W +: CODE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) bias_en_o <= 1'b1;
    else     bias_en_o <= biased;
  end

endmodule

// File: rtl/dual_out_ctrl_chk.sv
`timescale 1ns/1ps
module dual_out_ctrl_chk
  import dual_out_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CODE_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en_i,
  input logic [1:0]            wr_addr_i,
  input logic [2*NCH-1:0]      wr_data_i,
  input logic [NCH-1:0]        gate_o,
  input logic [NCH-1:0]        slew_o,
  input logic [NCH*CODE_W-1:0] ovld_code_o,
  input logic                  bias_en_o,
  input pwr_state_e            pwr_state,
  input logic [NCH-1:0]        cmd_bits,
  input logic [2*NCH-1:0]      mode_bits,
  input logic [NCH-1:0]        slew_bits
);

  logic sleep_wr, wake_wr, mode_wr;
  assign sleep_wr = wr_en_i && (wr_addr_i == A_PWR) && wr_data_i[0];
  assign wake_wr  = wr_en_i && (wr_addr_i == A_PWR) && wr_data_i[1] && !wr_data_i[0];
  assign mode_wr  = wr_en_i && (wr_addr_i == A_MODE);

  AST_SLEEP_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
    !bias_en_o |-> (gate_o == '0)); // R7

  AST_SLEEP_CLEARS_CMD: assert property (@(posedge clk) disable iff (rst)
    sleep_wr |=> (cmd_bits == '0)); // R8

  AST_SLEEP_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    ((pwr_state == PWR_SLEEP) && !mode_wr) |=> $stable(mode_bits)); // R8

  AST_NO_STRAY_WAKE: assert property (@(posedge clk) disable iff (rst)
    ((pwr_state == PWR_SLEEP) && !wake_wr) |=> (pwr_state == PWR_SLEEP)); // R9

  AST_WAKE_HOLDS_GATES: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == PWR_WAKE) |=> (gate_o == '0)); // R10

  AST_SLEW_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$stable(slew_bits) |=> (slew_o == $past(slew_bits))); // R5

  AST_CODE_QUIET_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == PWR_SLEEP) |=> (ovld_code_o == '0)); // R6

endmodule

bind dual_out_ctrl dual_out_ctrl_chk #(.NCH(NCH), .CODE_W(CODE_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .gate_o      (gate_o),
  .slew_o      (slew_o),
  .ovld_code_o (ovld_code_o),
  .bias_en_o   (bias_en_o),
  .pwr_state   (pwr_state),
  .cmd_bits    (cmd_bits),
  .mode_bits   (mode_bits),
  .slew_bits   (slew_bits)
);

// File: tb/dual_out_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_out_ctrl_tb_top;

  localparam int NCH  = 2;
  localparam int WAKE = 12;
  localparam int CW   = 4;
  localparam int C1   = 3;
  localparam int C2   = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      pin = '0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = '0;
  logic [3:0]      wr_data = '0;
  logic [1:0]      lim2 = '0;
  logic [1:0]      gate, slew;
  logic [7:0]      code;
  logic            bias;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  dual_out_ctrl #(
    .NCH(NCH), .WAKE_CYCLES(WAKE), .CODE_W(CW), .SR1_CODE(C1), .SR2_CODE(C2)
  ) dut_i (
    .clk(clk), .rst(rst), .pin_i(pin), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .lim2_i(lim2), .gate_o(gate), .slew_o(slew),
    .ovld_code_o(code), .bias_en_o(bias)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic expect_gate(logic [1:0] m, logic p, logic b);
    case (m)
      2'b00:   return p;
      2'b01:   return b;
      2'b10:   return p | b;
      default: return p & b;
    endcase
  endfunction

  initial begin
    ticks(4);
    rst = 1'b0;
    ticks(1);
    // R1 reset state
    chk("R1 gate", gate, 0);
    chk("R1 slew", slew, 0);
    chk("R1 code", code, 0);
    chk("R1 bias", bias, 1);
    pin = 2'b01;
    ticks(3);
    chk("R1 pin-only mode after reset", gate, 2'b01);

    // R4 pin latency: third edge
    pin = 2'b10;
    ticks(2);
    chk("R4 pin before third edge", gate, 2'b01);
    ticks(1);
    chk("R4 pin at third edge", gate, 2'b10);
    // R4 write latency: register at E, gate at E+1
    wr(2'd1, 4'b0101);
    chk("R4 write before E+1", gate, 2'b10);
    ticks(1);
    chk("R4 write at E+1", gate, 2'b00);

    // R2 R3 exhaustive sweep, both channels independent
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 16; v++) begin
        logic [1:0] e;
        wr(2'd1, 4'(m));
        wr(2'd0, {2'b00, 2'(v)});
        pin = 2'(v >> 2);
        ticks(3);
        e[0] = expect_gate(2'(m), v[2], v[0]);
        e[1] = expect_gate(2'(m >> 2), v[3], v[1]);
        chk("R2 R3 combine sweep", gate, e);
      end
    end

    // R5 slew pass-through
    for (int s = 0; s < 4; s++) begin
      wr(2'd2, 4'(s));
      ticks(1);
      chk("R5 slew", slew, s);
    end

    // R6 overload delay code
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 4; l++) begin
        logic [7:0] e;
        wr(2'd2, 4'(s));
        lim2 = 2'(l);
        ticks(2);
        for (int k = 0; k < 2; k++)
          e[k*4 +: 4] = l[k] ? (s[k] ? 4'(C2) : 4'(C1)) : 4'h0;
        chk("R6 code", code, e);
      end
    end

    // Sleep entry
    wr(2'd1, 4'b0101);
    wr(2'd0, 4'b0011);
    wr(2'd2, 4'b0010);
    lim2 = 2'b11;
    ticks(2);
    chk("R7 gates on before sleep", gate, 2'b11);
    wr(2'd3, 4'b0001);
    ticks(1);
    chk("R7 gates off in sleep", gate, 0);
    chk("R7 bias off in sleep", bias, 0);
    chk("R6 code zero in sleep", code, 0);
    chk("R5 slew kept in sleep", slew, 2'b10);

    // R9 nothing but a wake write wakes
    for (int i = 0; i < 8; i++) begin
      pin = 2'(i);
      ticks(1);
    end
    pin = 2'b11;
    wr(2'd3, 4'b0000);
    wr(2'd3, 4'b0100);
    wr(2'd2, 4'b0010);
    ticks(3);
    chk("R9 still asleep bias", bias, 0);
    chk("R9 still asleep gate", gate, 0);

    // R10 wake timing; R8 command cleared, mode kept
    wr(2'd3, 4'b0010);
    ticks(1);
    chk("R10 bias back at E0+1", bias, 1);
    ticks(WAKE - 1);
    chk("R10 gate held at E0+WAKE", gate, 0);
    ticks(1);
    chk("R8 command cleared by sleep", gate, 0);
    wr(2'd0, 4'b0001);
    ticks(1);
    chk("R8 mode kept across sleep", gate, 2'b01);
    chk("R8 slew kept across sleep", slew, 2'b10);

    // R11 writes during sleep stored, act after delay
    pin = 2'b00;
    wr(2'd3, 4'b0001);
    wr(2'd1, 4'b1010);
    wr(2'd0, 4'b0011);
    ticks(3);
    chk("R11 stored command not active asleep", gate, 0);
    wr(2'd3, 4'b0010);
    ticks(WAKE);
    chk("R11 gate held during wake delay", gate, 0);
    ticks(1);
    chk("R11 stored command active after wake", gate, 2'b11);

    // R10 wake write while awake ignored
    wr(2'd3, 4'b0010);
    ticks(2);
    chk("R10 wake while awake ignored gate", gate, 2'b11);
    chk("R10 wake while awake ignored bias", bias, 1);

    // R10 sleep bit wins over wake bit
    wr(2'd3, 4'b0011);
    ticks(1);
    chk("R10 sleep has priority", bias, 0);
    chk("R10 sleep has priority gate", gate, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule